// File: doc/BRIEF.md
# PIRQ and SCI Interrupt Level Router

This block steers eight shared PCI interrupt request levels (PIRQs) and one system control interrupt (SCI) level onto the input pins of a 16-line legacy interrupt controller and a 24-line I/O interrupt controller. Each PIRQ has a configuration byte. The byte chooses which legacy line the PIRQ drives, or blocks that path. Whatever that byte holds, each PIRQ also drives its own fixed line on the I/O controller. A separate control byte selects where the SCI goes. Every output line is a wired-OR of all the sources that currently target it.

Software writes the nine configuration bytes through a plain one-cycle write strobe. There is no back-pressure: a write is taken on the edge where the strobe is high. A lookup port lets an interrupt-mapping agent ask how a given PIRQ is routed at the moment. Inputs and configuration are captured on a clock edge. Every output is a register that shows the captured state one edge later.

Top module: `irq_level_router`

## Requirements
- R1: While reset is asserted, every output is 0, including the lookup mode and line. After reset, all eight route bytes hold 0x80 (disabled) and the SCI control byte holds 0x00 (SCI on line 9).
- R2: PIRQ k always drives I/O line 16+k, whatever its route byte holds.
- R3: When bit 7 of a route byte is 0 and its field in bits [4:0] is n, with n below 16, PIRQ k drives legacy line n. A legacy line is the OR of every enabled PIRQ that targets it.
- R4: When bit 7 of a route byte is 1, that PIRQ drives no legacy line.
- R5: An enabled route field of 16 to 31 drives no legacy line.
- R6: Bits [2:0] of the SCI control byte (address 8) select the SCI target: 0 selects line 9, 1 selects 10, 2 selects 11, 4 selects 20 and 5 selects 21. Codes 3, 6 and 7 leave the SCI unrouted. The stored SCI level is ORed into the I/O line of that number. When the number is below 16, it is also ORed into the legacy line of that number. I/O lines 0 to 15 carry nothing but the SCI.
- R7: The lookup returns a result one edge after lk_idx_i is sampled, using the route byte held at that edge. Mode 0 means legacy, with the line set to the route field. Mode 1 means I/O direct, with the line set to 16+idx; this is returned when bit 7 is set. Mode 2 means unrouted, with the line set to 0; this is returned when the field is 16 or more. Mode 3 never occurs.
- R8: A change on an input or a configuration write is captured on one edge and appears on the outputs on the next edge.
- R9: A write to address 9 to 15 changes no routing. Addresses 0 to 7 select the route bytes for PIRQ 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pirq_i | input | 8 | PIRQ levels, bit k is PIRQ k |
| sci_i | input | 1 | SCI level |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Write address: 0-7 route bytes, 8 SCI control |
| cfg_wdata_i | input | 8 | Write data byte |
| lk_idx_i | input | 3 | PIRQ index to look up |
| lk_mode_o | output | 2 | Lookup mode: 0 legacy, 1 I/O direct, 2 unrouted |
| lk_line_o | output | 5 | Lookup line number |
| pic_o | output | 16 | Legacy controller line levels |
| apic_o | output | 24 | I/O controller line levels |

## Verification
The bench builds the block with its default parameters: eight PIRQs, 16 legacy lines, 24 I/O lines and a 5-bit route field. The 5-bit field lets route values of 16 to 31 reach the unrouted path of the lookup. The 24 I/O lines let SCI targets 20 and 21 collide with the fixed lines of PIRQ 4 and 5. A behavioural model compares every output on every cycle. The stimulus covers directed routing patterns, wired-OR collisions, all eight SCI codes, writes to unused addresses and a long random phase.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int LINE_W = 5;
  localparam int DIS_BIT = 7;

  typedef enum logic [1:0] {
    LK_PIC  = 2'd0,
    LK_APIC = 2'd1,
    LK_NONE = 2'd2
  } lk_mode_e;

  typedef struct packed {
    logic              ok;
    logic [LINE_W-1:0] line;
  } sci_tgt_t;

  function automatic sci_tgt_t sci_decode(input logic [2:0] sel);
    sci_tgt_t t;
    t.ok = 1'b1;
    unique case (sel)
      3'd0: t.line = LINE_W'(9);
      3'd1: t.line = LINE_W'(10);
      3'd2: t.line = LINE_W'(11);
      3'd4: t.line = LINE_W'(20);
      3'd5: t.line = LINE_W'(21);
      default: begin
        t.ok   = 1'b0;
        t.line = '0;
      end
    endcase
    return t;
  endfunction
endpackage

// File: rtl/irq_route_cfg.sv
module irq_route_cfg #(
  parameter int NUM_PIRQ    = 8,
  parameter int ADDR_W      = 4,
  parameter int ACPI_ADDR   = 8,
  parameter logic [7:0] ROUTE_DEFAULT = 8'h80,
  parameter logic [7:0] ACPI_DEFAULT  = 8'h00
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [7:0]                   wdata_i,
  output logic [NUM_PIRQ-1:0][7:0]     route_o,
  output logic [7:0]                   acpi_o
);
  for (genvar k = 0; k < NUM_PIRQ; k++) begin : g_route
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    route_o[k] <= ROUTE_DEFAULT;
      else if (we_i && addr_i == ADDR_W'(k))         route_o[k] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      acpi_o <= ACPI_DEFAULT;
    else if (we_i && addr_i == ADDR_W'(ACPI_ADDR))   acpi_o <= wdata_i;
  end

  // R9: addresses past the control byte leave all routing untouched
  assert_unused_addr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i > ADDR_W'(ACPI_ADDR)) |=> ($stable(route_o) && $stable(acpi_o)));
endmodule

// File: rtl/irq_route_merge.sv
module irq_route_merge
  import irq_route_pkg::*;
#(
  parameter int NUM_PIRQ   = 8,
  parameter int PIC_LINES  = 16,
  parameter int APIC_LINES = 24,
  parameter int ROUTE_W    = 5
) (
  input  logic [NUM_PIRQ-1:0][7:0] route_i,
  input  logic [7:0]               acpi_i,
  input  logic [NUM_PIRQ-1:0]      pirq_i,
  input  logic                     sci_i,
  output logic [PIC_LINES-1:0]     pic_o,
  output logic [APIC_LINES-1:0]    apic_o
);
  sci_tgt_t sci_t;
  assign sci_t = sci_decode(acpi_i[2:0]);

  for (genvar n = 0; n < PIC_LINES; n++) begin : g_pic
    logic lvl;
    always_comb begin
      lvl = sci_i && sci_t.ok && (sci_t.line == LINE_W'(n));
      for (int k = 0; k < NUM_PIRQ; k++) begin
        if (!route_i[k][DIS_BIT] && route_i[k][ROUTE_W-1:0] == ROUTE_W'(n))
          lvl = lvl | pirq_i[k];
      end
    end
    assign pic_o[n] = lvl;
  end

  for (genvar g = 0; g < APIC_LINES; g++) begin : g_apic
    logic sci_hit;
    assign sci_hit = sci_i && sci_t.ok && (sci_t.line == LINE_W'(g));
    if (g >= PIC_LINES && g < PIC_LINES + NUM_PIRQ) begin : g_fixed
      assign apic_o[g] = pirq_i[g-PIC_LINES] | sci_hit;
    end else begin : g_sci_only
      assign apic_o[g] = sci_hit;
    end
  end
endmodule

// File: rtl/irq_route_lookup.sv
module irq_route_lookup
  import irq_route_pkg::*;
#(
  parameter int NUM_PIRQ  = 8,
  parameter int PIC_LINES = 16,
  parameter int ROUTE_W   = 5,
  localparam int IDX_W    = $clog2(NUM_PIRQ)
) (
  input  logic [NUM_PIRQ-1:0][7:0] route_i,
  input  logic [IDX_W-1:0]         idx_i,
  output lk_mode_e                 mode_o,
  output logic [LINE_W-1:0]        line_o
);
  logic [7:0] sel;
  assign sel = route_i[idx_i];

  always_comb begin
    if (sel[DIS_BIT]) begin
      mode_o = LK_APIC;
      line_o = LINE_W'(PIC_LINES) + LINE_W'(idx_i);
    end else if (int'(sel[ROUTE_W-1:0]) < PIC_LINES) begin
      mode_o = LK_PIC;
      line_o = LINE_W'(sel[ROUTE_W-1:0]);
    end else begin
      mode_o = LK_NONE;
      line_o = '0;
    end
  end
endmodule

// File: rtl/irq_level_router.sv
module irq_level_router
  import irq_route_pkg::*;
#(
  parameter int NUM_PIRQ   = 8,
  parameter int PIC_LINES  = 16,
  parameter int APIC_LINES = 24,
  parameter int ROUTE_W    = 5,
  parameter int ADDR_W     = 4,
  localparam int IDX_W     = $clog2(NUM_PIRQ)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PIRQ-1:0]   pirq_i,
  input  logic                  sci_i,
  input  logic                  cfg_we_i,
  input  logic [ADDR_W-1:0]     cfg_addr_i,
  input  logic [7:0]            cfg_wdata_i,
  input  logic [IDX_W-1:0]      lk_idx_i,
  output logic [1:0]            lk_mode_o,
  output logic [LINE_W-1:0]     lk_line_o,
  output logic [PIC_LINES-1:0]  pic_o,
  output logic [APIC_LINES-1:0] apic_o
);
  logic [NUM_PIRQ-1:0][7:0] route;
  logic [7:0]               acpi;
  logic [NUM_PIRQ-1:0]      pirq_q;
  logic                     sci_q;
  logic [PIC_LINES-1:0]     pic_nxt;
  logic [APIC_LINES-1:0]    apic_nxt;
  lk_mode_e                 lk_mode_nxt;
  logic [LINE_W-1:0]        lk_line_nxt;

  irq_route_cfg #(.NUM_PIRQ(NUM_PIRQ), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .route_o(route), .acpi_o(acpi));

  // capture stage: stored PIRQ and SCI levels
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pirq_q <= '0;
      sci_q  <= 1'b0;
    end else begin
      pirq_q <= pirq_i;
      sci_q  <= sci_i;
    end
  end

  irq_route_merge #(.NUM_PIRQ(NUM_PIRQ), .PIC_LINES(PIC_LINES),
                    .APIC_LINES(APIC_LINES), .ROUTE_W(ROUTE_W)) u_merge (
    .route_i(route), .acpi_i(acpi), .pirq_i(pirq_q), .sci_i(sci_q),
    .pic_o(pic_nxt), .apic_o(apic_nxt));

  irq_route_lookup #(.NUM_PIRQ(NUM_PIRQ), .PIC_LINES(PIC_LINES),
                     .ROUTE_W(ROUTE_W)) u_lookup (
    .route_i(route), .idx_i(lk_idx_i), .mode_o(lk_mode_nxt), .line_o(lk_line_nxt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pic_o     <= '0;
      apic_o    <= '0;
      lk_mode_o <= '0;
      lk_line_o <= '0;
    end else begin
      pic_o     <= pic_nxt;
      apic_o    <= apic_nxt;
      lk_mode_o <= lk_mode_nxt;
      lk_line_o <= lk_line_nxt;
    end
  end

  // R2: a stored PIRQ always reaches its fixed I/O line on the next edge
  for (genvar k = 0; k < NUM_PIRQ; k++) begin : g_chk
    assert_pirq_fixed_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pirq_q[k] |=> apic_o[PIC_LINES+k]);
  end

  assert_pic_has_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|pic_o) |-> $past((|pirq_q) || sci_q));

  assert_low_apic_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(apic_o[PIC_LINES-1:0]) <= 1);

  assert_low_apic_from_sci_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|apic_o[PIC_LINES-1:0]) |-> $past(sci_q));

  assert_lookup_mode_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_mode_o != 2'd3);

  assert_lookup_direct_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_mode_o == 2'd1) |-> (int'(lk_line_o) >= PIC_LINES));
endmodule

// File: tb/irq_level_router_tb_top.sv
module irq_level_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pirq = '0;
  logic        sci = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [2:0]  lk_idx = '0;
  logic [1:0]  lk_mode;
  logic [4:0]  lk_line;
  logic [15:0] pic;
  logic [23:0] apic;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  irq_level_router dut_i (
    .clk(clk), .rst_n(rst_n), .pirq_i(pirq), .sci_i(sci), .cfg_we_i(we),
    .cfg_addr_i(addr), .cfg_wdata_i(wdata), .lk_idx_i(lk_idx),
    .lk_mode_o(lk_mode), .lk_line_o(lk_line), .pic_o(pic), .apic_o(apic));

  // behavioural reference model
  int m_route[8];
  int m_acpi;
  int m_pirq;
  int m_sci;
  logic [15:0] e_pic;
  logic [23:0] e_apic;
  int e_mode, e_line;

  function automatic int sci_num(int c);
    case (c & 7)
      0: return 9;
      1: return 10;
      2: return 11;
      4: return 20;
      5: return 21;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_route[k]) m_route[k] = 'h80;
      m_acpi = 0; m_pirq = 0; m_sci = 0;
      e_pic = '0; e_apic = '0; e_mode = 0; e_line = 0;
    end else begin
      int t;
      int r;
      t = sci_num(m_acpi);
      e_pic = '0; e_apic = '0;
      for (int n = 0; n < 16; n++) begin
        for (int k = 0; k < 8; k++)
          if ((m_route[k] & 'h80) == 0 && (m_route[k] & 31) == n && m_pirq[k]) e_pic[n] = 1'b1;
        if (m_sci != 0 && t == n) e_pic[n] = 1'b1;
      end
      for (int g = 0; g < 24; g++) begin
        if (g >= 16 && m_pirq[g-16]) e_apic[g] = 1'b1;
        if (m_sci != 0 && t == g) e_apic[g] = 1'b1;
      end
      r = m_route[lk_idx];
      if (r & 'h80) begin e_mode = 1; e_line = 16 + int'(lk_idx); end
      else if ((r & 31) < 16) begin e_mode = 0; e_line = r & 31; end
      else begin e_mode = 2; e_line = 0; end
      m_pirq = int'(pirq);
      m_sci = int'(sci);
      if (we) begin
        if (addr < 8) m_route[addr] = int'(wdata);
        else if (addr == 8) m_acpi = int'(wdata);
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      checks++;
      if (pic !== e_pic) begin
        errors++;
        $display("FAIL %s pic actual %h expected %h", cur_req, pic, e_pic);
      end
      if (apic !== e_apic) begin
        errors++;
        $display("FAIL %s apic actual %h expected %h", cur_req, apic, e_apic);
      end
      if (int'(lk_mode) != e_mode || int'(lk_line) != e_line) begin
        errors++;
        $display("FAIL %s lookup actual %0d/%0d expected %0d/%0d",
                 cur_req, lk_mode, lk_line, e_mode, e_line);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    we = 1'b1; addr = 4'(a); wdata = 8'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic check_reset_zero();
    checks++;
    if (pic !== '0 || apic !== '0 || lk_mode !== '0 || lk_line !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs actual %h %h %0d %0d expected all 0",
               pic, apic, lk_mode, lk_line);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual hung expected finish");
    finish_run();
  end

  initial begin
    pirq = 8'hff; sci = 1'b1;
    cyc(3);
    cur_req = "R1";
    check_reset_zero();
    pirq = '0; sci = 1'b0;
    cyc(1);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    // R1 defaults: lookup every PIRQ, SCI to line 9
    for (int k = 0; k < 8; k++) begin lk_idx = 3'(k); cyc(1); end
    sci = 1'b1; cyc(3); sci = 1'b0; cyc(2);

    // R2 / R4: all routes disabled, only fixed lines move
    cur_req = "R2";
    pirq = 8'h01; cyc(2); pirq = 8'hA5; cyc(2); pirq = 8'hff; cyc(2); pirq = '0; cyc(2);
    cur_req = "R4";
    wr(3, 'h85); pirq = 8'h08; cyc(3);

    // R3: wired-OR collisions, R5: out-of-range field
    cur_req = "R3";
    wr(0, 5); wr(1, 5); wr(2, 11); wr(4, 3); wr(6, 0); wr(7, 15);
    pirq = 8'h01; cyc(2); pirq = 8'h03; cyc(2); pirq = 8'h02; cyc(2);
    pirq = 8'hD5; cyc(2); pirq = 8'hff; cyc(2);
    cur_req = "R5";
    wr(5, 17); pirq = 8'h20; cyc(2);
    wr(5, 31); lk_idx = 3'd5; cyc(2);

    // R6: every SCI code, with PIRQ 4 and 5 sharing lines 20 and 21
    cur_req = "R6";
    for (int c = 0; c < 8; c++) begin
      wr(8, c | 'hF0);
      sci = 1'b1; pirq = 8'h00; cyc(2);
      pirq = 8'h34; cyc(2);
      sci = 1'b0; cyc(2);
      sci = 1'b1; cyc(1); sci = 1'b1; cyc(1);
    end
    sci = 1'b0; pirq = '0; wr(8, 0);

    // R7: lookup sweep across all modes
    cur_req = "R7";
    for (int k = 0; k < 8; k++) begin lk_idx = 3'(k); cyc(1); end
    wr(2, 'h8B); lk_idx = 3'd2; cyc(2);

    // R9: writes to unused addresses
    cur_req = "R9";
    for (int a = 9; a < 16; a++) wr(a, 'h40 + a);
    pirq = 8'hff; sci = 1'b1;
    for (int k = 0; k < 8; k++) begin lk_idx = 3'(k); cyc(1); end
    pirq = '0; sci = 1'b0; cyc(2);

    // R8: random inputs, writes and lookups
    cur_req = "R8";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      pirq = 8'($urandom);
      sci = 1'($urandom);
      lk_idx = 3'($urandom);
      we = ($urandom % 4) == 0;
      addr = 4'($urandom);
      wdata = 8'($urandom);
    end
    @(negedge clk); we = 1'b0;

    // R1: reset in the middle of traffic
    cur_req = "R1";
    pirq = 8'hff; sci = 1'b1;
    cyc(2);
    cmp_on = 1'b0;
    rst_n = 1'b0;
    cyc(2);
    check_reset_zero();
    rst_n = 1'b1;
    cmp_on = 1'b1;
    for (int k = 0; k < 8; k++) begin lk_idx = 3'(k); cyc(1); end
    cyc(3);
    finish_run();
  end
endmodule